// File: doc/BRIEF.md
# Multiplexed ADC Acquisition Control

This block is the analog-input control logic of a byte-wide data acquisition card that occupies a 16-byte I/O window. A host reads and writes single bytes to select an input channel and gain code, choose how conversions are started, fire software conversions, clear a pending interrupt and read back the converted sample. The block starts the external converter through a start/done handshake. A start comes from one of three sources, depending on the trigger mode: a host strobe, a pacer tick, or the rising edge of an external trigger input.

When a conversion completes, the block latches the sample and drops an active-low data-ready flag. Depending on the mode it also raises either a DMA request, which is held until acknowledged, or an interrupt, which is held until the host writes the status address. A start that arrives while a conversion is still outstanding is discarded and recorded in a sticky overrun bit. The sample width is a parameter. The 12-bit build places the ready flag in the sample high byte. The 16-bit build places it in the status byte.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After synchronous reset the trigger mode is 0 (disabled), the control, range and status bytes read 0x00, the sample high byte reads 0x10 (flag not ready, sample 0), the mux byte reads 0x10 (channel 0, first bank), and irq, dma_req and conv_start are low.
- R2: Offset 0xB reads back the full byte last written. Only bits [2:0] select the trigger mode. Bits [7:4] (interrupt-line select) are stored and have no effect on triggering.
- R3: In mode 1 only, a write of any value to offset 0xC produces exactly one single-cycle conv_start pulse. In every other mode the write starts nothing.
- R4: A pacer_tick starts a conversion only in modes 2 and 6. Modes 0, 1 and the invalid codes 3, 4, 5 and 7 never start on a tick. With cfg_ext_trig high, the rising edge of ext_trig replaces the tick, and ticks are ignored.
- R5: On conv_done the sample is latched. In the 12-bit build, offset 0x5 reads {3'b000, rdy_n, sample[11:8]} and offset 0x4 reads sample[7:0]. Here rdy_n is bit 4 and reads 0 after a new sample. Reading 0x4 returns rdy_n to 1. Reading 0x5 leaves it unchanged, and repeated reads return the same sample.
- R6: In mode 6 a completed conversion sets irq one cycle after conv_done. irq stays high until any value is written to offset 0x8. Other modes never set irq.
- R7: In mode 2 a completed conversion sets dma_req, which stays high until a dma_ack pulse. irq stays low in mode 2.
- R8: A start request while a conversion is outstanding (started, done not yet seen) gives no conv_start. It sets status bit 0 (overrun), which stays 1 until reset.
- R9: A write to offset 0xA stores the channel in bits [3:0]. mux_bank is 2'b01 for channels 0-7 and 2'b10 for channels 8-15 when cfg_diff is low, and 2'b11 when cfg_diff is high. Offset 0xA reads {2'b00, mux_bank, channel}.
- R10: A write to offset 0x9 stores the gain code, drives it on range_sel and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset in the register window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, data valid the next cycle |
| bus_rdata | output | 8 | Registered read data |
| pacer_tick | input | 1 | Single-cycle pacer pulse |
| ext_trig | input | 1 | External trigger level, rising edge used |
| cfg_ext_trig | input | 1 | Selects ext_trig instead of pacer_tick |
| cfg_diff | input | 1 | Differential input configuration |
| conv_start | output | 1 | Single-cycle converter start |
| conv_done | input | 1 | Converter completion pulse |
| conv_sample | input | SAMPLE_W | Converted value, valid with conv_done |
| irq | output | 1 | End-of-conversion interrupt request |
| dma_req | output | 1 | Per-sample DMA request |
| dma_ack | input | 1 | DMA acknowledge pulse |
| range_sel | output | RANGE_W | Gain code |
| mux_chan | output | CH_W | Selected channel |
| mux_bank | output | 2 | Input bank enables |

## Verification
The assertions watch properties that must hold on every cycle:
- conv_start is never two cycles wide and never follows a cycle in a non-starting mode.
- The overrun bit never falls once set.
- A completion always drops the ready flag.
- irq and dma_req hold until their own clear.

Only the bench scenarios can show the rest:
- The exact byte layouts at each offset.
- Which mode and source combinations actually start a conversion.
- That a read of the low byte releases the ready flag while a read of the high byte does not.
- The bank enables for each channel and input configuration.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
  localparam logic [3:0] OFS_LO     = 4'h4;
  localparam logic [3:0] OFS_HI     = 4'h5;
  localparam logic [3:0] OFS_STAT   = 4'h8;
  localparam logic [3:0] OFS_RANGE  = 4'h9;
  localparam logic [3:0] OFS_MUX    = 4'hA;
  localparam logic [3:0] OFS_CTRL   = 4'hB;
  localparam logic [3:0] OFS_SWTRIG = 4'hC;

  localparam logic [2:0] TM_OFF      = 3'd0;
  localparam logic [2:0] TM_SOFT     = 3'd1;
  localparam logic [2:0] TM_PACE_DMA = 3'd2;
  localparam logic [2:0] TM_PACE_IRQ = 3'd6;

  function automatic logic is_paced(input logic [2:0] m);
    return (m == TM_PACE_DMA) || (m == TM_PACE_IRQ);
  endfunction
endpackage

// File: rtl/adc_host_regs.sv
module adc_host_regs
  import adc_acq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CH_W     = 4,
  parameter int RANGE_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          addr,
  input  logic [7:0]          wdata,
  input  logic                wr,
  input  logic                rd,
  output logic [7:0]          rdata,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                rdy_n,
  input  logic                overrun,
  input  logic                cfg_diff,
  output logic [2:0]          mode,
  output logic [RANGE_W-1:0]  range_sel,
  output logic [CH_W-1:0]     mux_chan,
  output logic [1:0]          mux_bank,
  output logic                sw_trig_wr,
  output logic                clr_irq_wr,
  output logic                lo_read
);
  logic [7:0]      ctrl_q;
  logic [CH_W-1:0] chan_d;
  logic [7:0]      hi_byte, stat_byte;

  assign mode       = ctrl_q[2:0];
  assign sw_trig_wr = wr && (addr == OFS_SWTRIG);
  assign clr_irq_wr = wr && (addr == OFS_STAT);
  assign lo_read    = rd && (addr == OFS_LO);
  assign chan_d     = (wr && addr == OFS_MUX) ? wdata[CH_W-1:0] : mux_chan;

  generate
    if (SAMPLE_W == 16) begin : g_wide
      assign hi_byte   = sample[15:8];
      assign stat_byte = {2'b00, rdy_n, 4'b0000, overrun};
    end else begin : g_narrow
      logic [11:0] s12;
      assign s12       = 12'(sample);
      assign hi_byte   = {3'b000, rdy_n, s12[11:8]};
      assign stat_byte = {7'b0, overrun};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      range_sel <= '0;
      mux_chan  <= '0;
      mux_bank  <= '0;
      rdata     <= '0;
    end else begin
      mux_chan <= chan_d;
      mux_bank <= cfg_diff ? 2'b11 : (chan_d[CH_W-1] ? 2'b10 : 2'b01);
      if (wr && addr == OFS_CTRL)  ctrl_q    <= wdata;
      if (wr && addr == OFS_RANGE) range_sel <= wdata[RANGE_W-1:0];
      if (rd) begin
        case (addr)
          OFS_LO:    rdata <= sample[7:0];
          OFS_HI:    rdata <= hi_byte;
          OFS_STAT:  rdata <= stat_byte;
          OFS_RANGE: rdata <= 8'(range_sel);
          OFS_MUX:   rdata <= 8'({mux_bank, mux_chan});
          OFS_CTRL:  rdata <= ctrl_q;
          default:   rdata <= 8'h00;
        endcase
      end
    end
  end

  p_mode_from_ctrl_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_CTRL) |=> (mode == $past(wdata[2:0])));
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       sw_trig_wr,
  input  logic       pacer_tick,
  input  logic       ext_trig,
  input  logic       cfg_ext_trig,
  input  logic       conv_done,
  output logic       conv_start,
  output logic       overrun
);
  logic ext_q, busy, hw_evt, start_req, start_ok;

  assign hw_evt    = cfg_ext_trig ? (ext_trig && !ext_q) : pacer_tick;
  assign start_req = ((mode == TM_SOFT) && sw_trig_wr) || (is_paced(mode) && hw_evt);
  assign start_ok  = start_req && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q      <= 1'b0;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      ext_q      <= ext_trig;
      conv_start <= start_ok;
      if (start_ok)       busy <= 1'b1;
      else if (conv_done) busy <= 1'b0;
      if (start_req && busy) overrun <= 1'b1;
    end
  end

  p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  p_no_start_badmode_r4: assert property (@(posedge clk) disable iff (rst)
    !((mode == TM_SOFT) || is_paced(mode)) |=> !conv_start);
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

// File: rtl/adc_result.sv
module adc_result
  import adc_acq_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          mode,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_sample,
  input  logic                lo_read,
  input  logic                clr_irq_wr,
  input  logic                dma_ack,
  output logic [SAMPLE_W-1:0] sample,
  output logic                rdy_n,
  output logic                irq,
  output logic                dma_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sample  <= '0;
      rdy_n   <= 1'b1;
      irq     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      if (conv_done) begin
        sample <= conv_sample;
        rdy_n  <= 1'b0;
      end else if (lo_read) begin
        rdy_n  <= 1'b1;
      end
      if (conv_done && mode == TM_PACE_IRQ) irq <= 1'b1;
      else if (clr_irq_wr)                  irq <= 1'b0;
      if (conv_done && mode == TM_PACE_DMA) dma_req <= 1'b1;
      else if (dma_ack)                     dma_req <= 1'b0;
    end
  end

  p_ready_on_done_r5: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !rdy_n);
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_irq_wr) |=> irq);
  p_dma_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_ack) |=> dma_req);
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl #(
  parameter int SAMPLE_W = 12,
  parameter int CH_W     = 4,
  parameter int RANGE_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [7:0]          bus_rdata,
  input  logic                pacer_tick,
  input  logic                ext_trig,
  input  logic                cfg_ext_trig,
  input  logic                cfg_diff,
  output logic                conv_start,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_sample,
  output logic                irq,
  output logic                dma_req,
  input  logic                dma_ack,
  output logic [RANGE_W-1:0]  range_sel,
  output logic [CH_W-1:0]     mux_chan,
  output logic [1:0]          mux_bank
);
  logic [2:0]          mode;
  logic                sw_trig_wr, clr_irq_wr, lo_read, rdy_n, overrun;
  logic [SAMPLE_W-1:0] sample;

  adc_host_regs #(.SAMPLE_W(SAMPLE_W), .CH_W(CH_W), .RANGE_W(RANGE_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
    .rd(bus_rd), .rdata(bus_rdata), .sample(sample), .rdy_n(rdy_n),
    .overrun(overrun), .cfg_diff(cfg_diff), .mode(mode), .range_sel(range_sel),
    .mux_chan(mux_chan), .mux_bank(mux_bank), .sw_trig_wr(sw_trig_wr),
    .clr_irq_wr(clr_irq_wr), .lo_read(lo_read));

  adc_trig_ctrl u_trig (
    .clk(clk), .rst(rst), .mode(mode), .sw_trig_wr(sw_trig_wr),
    .pacer_tick(pacer_tick), .ext_trig(ext_trig), .cfg_ext_trig(cfg_ext_trig),
    .conv_done(conv_done), .conv_start(conv_start), .overrun(overrun));

  adc_result #(.SAMPLE_W(SAMPLE_W)) u_result (
    .clk(clk), .rst(rst), .mode(mode), .conv_done(conv_done),
    .conv_sample(conv_sample), .lo_read(lo_read), .clr_irq_wr(clr_irq_wr),
    .dma_ack(dma_ack), .sample(sample), .rdy_n(rdy_n), .irq(irq),
    .dma_req(dma_req));
endmodule

// File: tb/adc_acq_ctrl_bench.sv
module adc_acq_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic        pacer_tick = 1'b0, ext_trig = 1'b0, cfg_ext_trig = 1'b0, cfg_diff = 1'b0;
  logic        conv_start, conv_done = 1'b0, irq, dma_req, dma_ack = 1'b0;
  logic [11:0] conv_sample = '0;
  logic [7:0]  range_sel;
  logic [3:0]  mux_chan;
  logic [1:0]  mux_bank;

  int checks = 0, fails = 0, start_cnt = 0;
  bit finished = 1'b0, rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  adc_acq_ctrl u_adc_acq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pacer_tick(pacer_tick), .ext_trig(ext_trig), .cfg_ext_trig(cfg_ext_trig),
    .cfg_diff(cfg_diff), .conv_start(conv_start), .conv_done(conv_done),
    .conv_sample(conv_sample), .irq(irq), .dma_req(dma_req), .dma_ack(dma_ack),
    .range_sel(range_sel), .mux_chan(mux_chan), .mux_bank(mux_bank));

  always @(posedge clk) begin
    if (conv_start) start_cnt <= start_cnt + 1;
    rd_seen <= bus_rd;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected byte per completed read
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 16'd1, 16'd0);
      else chk(tag_q.pop_front(), {8'h00, bus_rdata}, {8'h00, exp_q.pop_front()});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic done(input logic [11:0] s);
    @(negedge clk); conv_done = 1'b1; conv_sample = s;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); pacer_tick = 1'b1;
    @(negedge clk); pacer_tick = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    rd(4'hB, 8'h00, "R1 ctrl after reset");
    rd(4'h9, 8'h00, "R1 range after reset");
    rd(4'h8, 8'h00, "R1 status after reset");
    rd(4'h5, 8'h10, "R1 high byte after reset");
    rd(4'hA, 8'h10, "R1 mux after reset");
    chk("R1 irq", irq, 0); chk("R1 dma_req", dma_req, 0); chk("R1 starts", start_cnt, 0);

    // R2 control readback, upper field inert
    wr(4'hB, 8'hA9);
    rd(4'hB, 8'hA9, "R2 ctrl readback");
    wr(4'hB, 8'h51);
    rd(4'hB, 8'h51, "R2 ctrl readback 2");

    // R3 software trigger in mode 1
    base = start_cnt;
    wr(4'hC, 8'h5A); idle(2);
    chk("R3 one start", start_cnt, base + 1);
    done(12'hABC);
    chk("R6 no irq in mode 1", irq, 0);
    rd(4'h5, 8'h0A, "R5 high byte fresh");
    rd(4'h5, 8'h0A, "R5 high read keeps ready");
    rd(4'h4, 8'hBC, "R5 low byte");
    rd(4'h5, 8'h1A, "R5 ready released by low read");
    rd(4'h4, 8'hBC, "R5 low byte repeat");

    // R3 negative, R4 / R7 DMA mode
    wr(4'hB, 8'h02);
    base = start_cnt;
    wr(4'hC, 8'h00); idle(2);
    chk("R3 sw trig ignored in mode 2", start_cnt, base);
    tick(); idle(1);
    chk("R4 tick starts mode 2", start_cnt, base + 1);
    done(12'h123);
    chk("R7 dma_req set", dma_req, 1);
    chk("R7 no irq in mode 2", irq, 0);
    idle(3);
    chk("R7 dma_req held", dma_req, 1);
    @(negedge clk); dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
    chk("R7 dma_req cleared by ack", dma_req, 0);

    // R6 interrupt mode
    wr(4'hB, 8'h06);
    base = start_cnt;
    tick(); idle(1);
    chk("R4 tick starts mode 6", start_cnt, base + 1);
    done(12'h456);
    chk("R6 irq set", irq, 1);
    rd(4'h5, 8'h04, "R5 high byte 0x456");
    chk("R6 irq held after reads", irq, 1);
    wr(4'h8, 8'h77);
    chk("R6 irq cleared by status write", irq, 0);
    chk("R7 no dma in mode 6", dma_req, 0);

    // R4 non-starting modes
    base = start_cnt;
    foreach (exp_q[i]) ; // no-op keeps queue state visible
    wr(4'hB, 8'h03); tick();
    wr(4'hB, 8'h05); tick();
    wr(4'hB, 8'h07); tick();
    wr(4'hB, 8'h00); tick();
    wr(4'hB, 8'h01); tick(); idle(2);
    chk("R4 no tick start in modes 0,1,3,5,7", start_cnt, base);

    // R4 external trigger replaces tick
    wr(4'hB, 8'h06); cfg_ext_trig = 1'b1;
    base = start_cnt;
    tick(); idle(2);
    chk("R4 tick ignored with ext select", start_cnt, base);
    @(negedge clk); ext_trig = 1'b1;
    idle(4);
    chk("R4 ext rising edge starts once", start_cnt, base + 1);
    ext_trig = 1'b0;
    done(12'h001);
    wr(4'h8, 8'h00);
    cfg_ext_trig = 1'b0;

    // R8 overrun
    wr(4'hB, 8'h01);
    rd(4'h8, 8'h00, "R8 no overrun yet");
    base = start_cnt;
    wr(4'hC, 8'h01);
    wr(4'hC, 8'h01); idle(2);
    chk("R8 busy start dropped", start_cnt, base + 1);
    rd(4'h8, 8'h01, "R8 overrun set");
    done(12'h222);
    wr(4'hC, 8'h01); idle(2);
    chk("R8 start after done", start_cnt, base + 2);
    done(12'h333);
    rd(4'h8, 8'h01, "R8 overrun sticky");

    // R9 mux
    wr(4'hA, 8'h0B);
    chk("R9 chan 11", mux_chan, 11); chk("R9 bank upper", mux_bank, 2'b10);
    rd(4'hA, 8'h2B, "R9 mux readback ch11");
    wr(4'hA, 8'h05);
    chk("R9 bank lower", mux_bank, 2'b01);
    rd(4'hA, 8'h15, "R9 mux readback ch5");
    cfg_diff = 1'b1; idle(2);
    chk("R9 bank diff", mux_bank, 2'b11);
    rd(4'hA, 8'h35, "R9 mux readback diff");
    cfg_diff = 1'b0;

    // R10 range
    wr(4'h9, 8'h03);
    chk("R10 range_sel", range_sel, 3);
    rd(4'h9, 8'h03, "R10 range readback");

    // R1 reset again
    @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; idle(2);
    rd(4'h8, 8'h00, "R1 status cleared by reset");
    rd(4'hB, 8'h00, "R1 ctrl cleared by reset");
    chk("R1 range after reset", range_sel, 0);

    idle(2);
    finished = 1'b1;
    summary();
  end
endmodule